// File: doc/BRIEF.md
# Sequential MLP Inference Engine

This block evaluates a small fixed-point multilayer perceptron with a 6-8-8-1 topology. Six inputs feed a first hidden layer of eight neurons. That layer feeds a second hidden layer of eight neurons, which feeds one output neuron. A single signed 16x16 multiplier and a 32-bit accumulator are shared by every neuron of every layer. A small sequencer walks the neurons one by one, and for each neuron it walks that neuron's inputs one by one.

Software first loads the weights and biases through a word-wide write port while the engine is idle. It then applies an input vector, already normalised to the range 0 to 1, and pulses `start_i`. The engine performs one multiply-accumulate per clock. After the last product of each neuron it spends one extra clock adding the bias and applying the activation. When the linear output is ready, it raises `done_o` for one cycle and holds the value on `result_o`.

Top module: `mlp_engine`

## Requirements
- R1: After reset, `done_o`, `busy_o` and `result_o` are all zero, and every weight and bias reads as zero.
- R2: All values are Q1.14 signed. Each product is formed at full width and shifted right arithmetically by 14 bits, rounding toward minus infinity. The shifted products are summed in a 32-bit accumulator that starts at zero for every neuron. The neuron's bias, sign-extended, is added once after the last product.
- R3: A hidden-layer neuron whose sum is negative produces 0. A sum above 32767 produces 32767. Any other sum is kept as-is in 16 bits.
- R4: The output neuron is linear. `result_o` is its full 32-bit signed sum plus bias, with no clamping and no saturation.
- R5: The parameter address map is as follows. The weight from input j to first-layer neuron i is at i*6+j. The weight from first-layer output j to second-layer neuron i is at 48+i*8+j. The weight from second-layer output j to the output neuron is at 112+j. First-layer biases are at 120+i, second-layer biases at 128+i, and the output bias at 136. Input element j of `x_i` occupies bits [16j+15:16j].
- R6: `done_o` goes high exactly 137 clock edges after the edge that accepts `start_i`, and it stays high for one cycle only. `busy_o` is high from the accepting edge until `done_o` rises, and it is low while `done_o` is high.
- R7: A `start_i` pulse while `busy_o` is high is ignored. It changes neither the running inference's timing nor its result.
- R8: A parameter write while `busy_o` is high is dropped. It affects neither the running inference nor any later one.
- R9: The input vector is captured on the accepting edge. Later changes of `x_i` do not affect that inference.
- R10: `result_o` holds its value except on the cycle that `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an inference when idle |
| x_i | input | 96 | Six Q1.14 inputs, element j at bits [16j+15:16j] |
| wr_en_i | input | 1 | Parameter write strobe, honoured only when idle |
| wr_addr_i | input | 8 | Parameter address (see R5) |
| wr_data_i | input | 16 | Q1.14 weight or bias |
| busy_o | output | 1 | Inference in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| result_o | output | 32 | Signed linear output, Q.14 in 32 bits |

## Verification
The hardest situations to reach from the ports are the collisions inside a running inference. These are a second start, a parameter write, and an input change that arrive in the middle of the 137 cycles. The stimulus counts clocks after the accepting edge and injects each collision at a chosen cycle inside a first-layer or second-layer neuron. It then compares the result and the latency against values computed for undisturbed parameters and inputs. A dropped write is confirmed by a second, undisturbed run that must give the same value. Directed weight sets reach both clamp limits and the negative-to-zero clamp. Single-weight sets pin down the address map. A sweep of pseudo-random parameter sets and inputs covers general arithmetic, including arithmetic-shift rounding of negative products.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
  localparam int N_IN    = 6;
  localparam int N_HID   = 8;
  localparam int DW      = 16;
  localparam int ACC_W   = 32;
  localparam int FRAC    = 14;

  localparam int W0_N    = N_IN * N_HID;
  localparam int W1_BASE = W0_N;
  localparam int W2_BASE = W1_BASE + N_HID * N_HID;
  localparam int B_BASE  = W2_BASE + N_HID;
  localparam int N_PARAM = B_BASE + 2 * N_HID + 1;
  localparam int PA_W    = $clog2(N_PARAM);
  localparam int IX_W    = $clog2(N_HID);
  localparam int NU_W    = $clog2(N_HID);

  typedef logic signed [DW-1:0] word_t;
  typedef enum logic [1:0] {ST_IDLE, ST_MAC, ST_FIN} state_e;
endpackage

// File: rtl/mlp_param_store.sv
module mlp_param_store
  import mlp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [PA_W-1:0] waddr_i,
  input  word_t           wdata_i,
  input  logic [PA_W-1:0] raddr_w_i,
  input  logic [PA_W-1:0] raddr_b_i,
  output word_t           rdata_w_o,
  output word_t           rdata_b_o
);
  word_t mem_q [N_PARAM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_PARAM; k++) mem_q[k] <= '0;
    end else if (we_i && (int'(waddr_i) < N_PARAM)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_w_o = mem_q[raddr_w_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/mlp_mac.sv
module mlp_mac
  import mlp_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    fin_i,
  input  word_t                   a_i,
  input  word_t                   w_i,
  input  word_t                   b_i,
  output logic signed [ACC_W-1:0] sum_o,
  output word_t                   act_o
);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(2 ** (DW - 1) - 1);

  logic signed [ACC_W-1:0] a_ext, w_ext, b_ext, prod, term, acc_q;

  assign a_ext = ACC_W'(a_i);
  assign w_ext = ACC_W'(w_i);
  assign b_ext = ACC_W'(b_i);
  assign prod  = a_ext * w_ext;
  assign term  = prod >>> FRAC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (fin_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_q + term;
  end

  // bias joins only on the finishing cycle
  assign sum_o = acc_q + b_ext;

  always_comb begin
    if (sum_o[ACC_W-1])      act_o = '0;
    else if (sum_o > SAT_HI) act_o = SAT_HI[DW-1:0];
    else                     act_o = sum_o[DW-1:0];
  end

  p_acc_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> (acc_q == '0));
endmodule

// File: rtl/mlp_seq.sv
module mlp_seq
  import mlp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            busy_o,
  output logic            accept_o,
  output logic            mac_en_o,
  output logic            fin_o,
  output logic            last_o,
  output logic [1:0]      layer_o,
  output logic [NU_W-1:0] neu_o,
  output logic [IX_W-1:0] idx_o,
  output logic [PA_W-1:0] waddr_o,
  output logic [PA_W-1:0] baddr_o
);
  state_e          st_q;
  logic [1:0]      lay_q;
  logic [NU_W-1:0] neu_q;
  logic [IX_W-1:0] idx_q;
  logic [IX_W-1:0] last_idx;
  logic [NU_W-1:0] last_neu;

  assign last_idx = (lay_q == 2'd0) ? IX_W'(N_IN - 1) : IX_W'(N_HID - 1);
  assign last_neu = (lay_q == 2'd2) ? '0 : NU_W'(N_HID - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      lay_q <= '0;
      neu_q <= '0;
      idx_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_MAC;
          lay_q <= '0;
          neu_q <= '0;
          idx_q <= '0;
        end
        ST_MAC: begin
          if (idx_q == last_idx) st_q <= ST_FIN;
          else                   idx_q <= idx_q + 1'b1;
        end
        ST_FIN: begin
          idx_q <= '0;
          if (neu_q == last_neu) begin
            neu_q <= '0;
            if (lay_q == 2'd2) begin
              st_q <= ST_IDLE;
            end else begin
              lay_q <= lay_q + 1'b1;
              st_q  <= ST_MAC;
            end
          end else begin
            neu_q <= neu_q + 1'b1;
            st_q  <= ST_MAC;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign accept_o = (st_q == ST_IDLE) && start_i;
  assign mac_en_o = (st_q == ST_MAC);
  assign fin_o    = (st_q == ST_FIN);
  assign last_o   = fin_o && (lay_q == 2'd2);
  assign layer_o  = lay_q;
  assign neu_o    = neu_q;
  assign idx_o    = idx_q;

  always_comb begin
    int wa;
    case (lay_q)
      2'd0:    wa = int'(neu_q) * N_IN + int'(idx_q);
      2'd1:    wa = W1_BASE + int'(neu_q) * N_HID + int'(idx_q);
      default: wa = W2_BASE + int'(idx_q);
    endcase
    waddr_o = PA_W'(wa);
    baddr_o = PA_W'(B_BASE + int'(lay_q) * N_HID + int'(neu_q));
  end

  p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MAC && idx_q != last_idx) |=>
      (st_q == ST_MAC && idx_q == $past(idx_q) + 1'b1));

  p_layer_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lay_q != 2'd3);
endmodule

// File: rtl/mlp_engine.sv
module mlp_engine
  import mlp_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [N_IN*DW-1:0]      x_i,
  input  logic                    wr_en_i,
  input  logic [PA_W-1:0]         wr_addr_i,
  input  logic [DW-1:0]           wr_data_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [ACC_W-1:0] result_o
);
  logic            accept, mac_en, fin, last;
  logic [1:0]      layer;
  logic [NU_W-1:0] neu;
  logic [IX_W-1:0] idx;
  logic [PA_W-1:0] waddr, baddr;
  word_t           wdat, bdat, opnd, act;
  logic signed [ACC_W-1:0] sum;

  word_t x_q  [N_IN];
  word_t h0_q [N_HID];
  word_t h1_q [N_HID];
  logic  done_q;
  logic signed [ACC_W-1:0] result_q;

  mlp_seq u_seq (
    .clk_i, .rst_ni, .start_i,
    .busy_o, .accept_o(accept), .mac_en_o(mac_en), .fin_o(fin), .last_o(last),
    .layer_o(layer), .neu_o(neu), .idx_o(idx), .waddr_o(waddr), .baddr_o(baddr)
  );

  mlp_param_store u_store (
    .clk_i, .rst_ni,
    .we_i(wr_en_i && !busy_o), .waddr_i(wr_addr_i), .wdata_i(wr_data_i),
    .raddr_w_i(waddr), .raddr_b_i(baddr), .rdata_w_o(wdat), .rdata_b_o(bdat)
  );

  mlp_mac u_mac (
    .clk_i, .rst_ni, .en_i(mac_en), .fin_i(fin),
    .a_i(opnd), .w_i(wdat), .b_i(bdat), .sum_o(sum), .act_o(act)
  );

  for (genvar g = 0; g < N_IN; g++) begin : g_xcap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     x_q[g] <= '0;
      else if (accept) x_q[g] <= x_i[g*DW +: DW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_HID; k++) begin
        h0_q[k] <= '0;
        h1_q[k] <= '0;
      end
    end else if (fin) begin
      if (layer == 2'd0)      h0_q[neu] <= act;
      else if (layer == 2'd1) h1_q[neu] <= act;
    end
  end

  always_comb begin
    case (layer)
      2'd0:    opnd = x_q[idx];
      2'd1:    opnd = h0_q[idx];
      default: opnd = h1_q[idx];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= last;
      if (last) result_q <= sum;
    end
  end

  assign done_o   = done_q;
  assign result_o = result_q;

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_at_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
endmodule

// File: tb/mlp_engine_bench.sv
module mlp_engine_bench;
  import mlp_pkg::*;

  localparam int CLK_NS  = 8;
  localparam int LATENCY = 137;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    start_i = 1'b0;
  logic [N_IN*DW-1:0]      x_i = '0;
  logic                    wr_en_i = 1'b0;
  logic [PA_W-1:0]         wr_addr_i = '0;
  logic [DW-1:0]           wr_data_i = '0;
  logic                    busy_o, done_o;
  logic signed [ACC_W-1:0] result_o;

  int checks = 0;
  int errors = 0;
  int pm [N_PARAM];
  int xv [N_IN];
  int unsigned seed = 32'h1234_5678;

  always #(CLK_NS / 2) clk_i = ~clk_i;

  mlp_engine u_mlp_engine (
    .clk_i, .rst_ni, .start_i, .x_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .busy_o, .done_o, .result_o
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int nxt();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return int'(seed & 32'h7fff_ffff);
  endfunction

  function automatic int ms(int a, int b);
    int p;
    p = a * b;
    return p >>> FRAC;
  endfunction

  function automatic int act_h(int s);
    if (s < 0) return 0;
    if (s > 32767) return 32767;
    return s;
  endfunction

  function automatic int ref_out();
    int h0 [N_HID];
    int h1 [N_HID];
    int s;
    for (int i = 0; i < N_HID; i++) begin
      s = 0;
      for (int j = 0; j < N_IN; j++) s += ms(xv[j], pm[i*N_IN+j]);
      h0[i] = act_h(s + pm[B_BASE+i]);
    end
    for (int i = 0; i < N_HID; i++) begin
      s = 0;
      for (int j = 0; j < N_HID; j++) s += ms(h0[j], pm[W1_BASE+i*N_HID+j]);
      h1[i] = act_h(s + pm[B_BASE+N_HID+i]);
    end
    s = 0;
    for (int j = 0; j < N_HID; j++) s += ms(h1[j], pm[W2_BASE+j]);
    return s + pm[B_BASE+2*N_HID];
  endfunction

  task automatic wr(int a, int v);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_addr_i = PA_W'(a);
    wr_data_i = DW'(v);
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic load_all();
    for (int a = 0; a < N_PARAM; a++) wr(a, pm[a]);
  endtask

  task automatic clear_pm();
    for (int a = 0; a < N_PARAM; a++) pm[a] = 0;
  endtask

  task automatic drive_x();
    for (int j = 0; j < N_IN; j++) x_i[j*DW +: DW] = DW'(xv[j]);
  endtask

  // kind: 0 none, 1 start while busy, 2 write while busy, 3 change x_i
  task automatic run(string tag, int kind, int at);
    int exp, n;
    exp = ref_out();
    drive_x();
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 400) begin
      if (n == 5) chk({tag, " R6 busy"}, int'(busy_o), 1);
      if (n == at) begin
        if (kind == 1) begin
          start_i = 1'b1;
          x_i = ~x_i;
        end
        if (kind == 2) begin
          wr_en_i   = 1'b1;
          wr_addr_i = PA_W'(B_BASE + 2 * N_HID);
          wr_data_i = DW'(1000);
        end
        if (kind == 3) x_i = {N_IN{16'h2a5c}};
      end
      @(negedge clk_i);
      start_i = 1'b0;
      wr_en_i = 1'b0;
      n++;
    end
    chk({tag, " R6 latency"}, n, LATENCY);
    chk({tag, " result"}, int'(result_o), exp);
    chk({tag, " R6 idle at done"}, int'(busy_o), 0);
    @(negedge clk_i);
    chk({tag, " R6 done pulse"}, int'(done_o), 0);
  endtask

  task automatic rand_x();
    for (int j = 0; j < N_IN; j++) xv[j] = nxt() % 16385;
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int keep;
    clear_pm();
    for (int j = 0; j < N_IN; j++) xv[j] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 done", int'(done_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 result", int'(result_o), 0);

    // R1 R2: parameters from reset are zero
    rand_x();
    run("R1 zero params", 0, -1);

    // R2 R4: bias added once per neuron, linear negative output
    clear_pm();
    for (int i = 0; i < N_HID; i++) pm[B_BASE+i] = 100;
    for (int a = W1_BASE; a < W2_BASE; a++) pm[a] = 16384;
    for (int a = W2_BASE; a < B_BASE; a++) pm[a] = 16384;
    pm[B_BASE+2*N_HID] = -5;
    load_all();
    run("R2 bias chain", 0, -1);
    chk("R2 bias value", int'(result_o), 6395);
    clear_pm();
    pm[B_BASE+2*N_HID] = -5;
    load_all();
    run("R4 linear neg", 0, -1);

    // R3 R4: upper clamp in both hidden layers, unclamped output
    clear_pm();
    for (int a = 0; a < B_BASE; a++) pm[a] = 16384;
    load_all();
    for (int j = 0; j < N_IN; j++) xv[j] = 16384;
    run("R3 sat high", 0, -1);
    chk("R4 no clamp", int'(result_o), 262136);

    // R3: negative sums become zero
    clear_pm();
    for (int a = 0; a < W0_N; a++) pm[a] = -16384;
    for (int i = 0; i < N_HID; i++) pm[B_BASE+N_HID+i] = 50;
    for (int a = W2_BASE; a < B_BASE; a++) pm[a] = 16384;
    load_all();
    run("R3 relu", 0, -1);
    chk("R3 relu value", int'(result_o), 400);

    // R5: single path through the address map
    clear_pm();
    pm[3*N_IN+2] = 16384;
    pm[W1_BASE+5*N_HID+3] = 16384;
    pm[W2_BASE+5] = -16384;
    load_all();
    for (int j = 0; j < N_IN; j++) xv[j] = 0;
    xv[2] = 8192;
    run("R5 map", 0, -1);
    chk("R5 map value", int'(result_o), -8192);

    // R2 R3 R4: pseudo-random sweep
    for (int s = 0; s < 8; s++) begin
      for (int a = 0; a < N_PARAM; a++) pm[a] = (nxt() % 16384) - 8192;
      load_all();
      for (int v = 0; v < 3; v++) begin
        rand_x();
        run($sformatf("R2 sweep %0d.%0d", s, v), 0, -1);
      end
    end

    // R7: start while busy, inside a first-layer neuron
    rand_x();
    run("R7 start busy", 1, 40);
    // R8: write while busy, then confirm nothing stored
    run("R8 write busy", 2, 60);
    run("R8 after write", 0, -1);
    // R9: input change mid-run
    run("R9 x change", 3, 10);

    // R10: result holds while idle and inputs move
    keep = int'(result_o);
    x_i = ~x_i;
    repeat (20) @(negedge clk_i);
    chk("R10 hold", int'(result_o), keep);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule